// File: doc/BRIEF.md
# Bank-Interleave Command Sequencer

This block produces an endless stream of DRAM commands for a peak-current test of a DDR2-style device. In every loop it visits the eight banks in ascending order. Each bank gets a row open (activate) followed in the next slot by a read that also closes the row (auto precharge), with burst length 4. Idle (deselect) slots are placed between bank pairs. Their number depends on the chosen speed bin and device width, so that activates stay far enough apart for the activate-spacing and four-activate-window limits of that grade.

The speed-bin and width selects are captured only when a loop begins. A loop that is already running always finishes with the shape it started with. During idle slots only chip-select goes inactive. The other command lines, the bank and the address keep the values of the last real command. One combination has no defined pattern: the x16 width with the fastest bin. For that combination the block raises an error flag and issues nothing but deselects. Every output is registered, so the pins show a slot one clock after the sequencer enters it.

Top module: `ilv_cmd_seq`

## Requirements
- R1: After reset, cs_n, ras_n, cas_n and we_n are 1, bank and addr are 0, and cfg_err and loop_start are 0.
- R2: Commands are active-low. An activate is cs_n=0, ras_n=0, cas_n=1, we_n=1 with addr = ROW_ADDR (default 0x0123). A read with auto precharge is cs_n=0, ras_n=1, cas_n=0, we_n=1 with addr = COL_ADDR with bit AP_BIT set (default 0x0408). A deselect is cs_n=1.
- R3: Banks are visited in the order 0,1,…,7, and every activate is followed in the very next slot by a read to the same bank.
- R4: With speed_sel=0 (400 bin) and wide_org=0 (x4/x8), the loop has 16 slots: the eight activate/read pairs back to back, with no deselects.
- R5: With speed_sel=1, wide_org=0, or with speed_sel=0, wide_org=1, the only deselects are two after the read of bank 3 and two after the read of bank 7, giving 20 slots.
- R6: With speed_sel=2, wide_org=0, one deselect follows every pair, plus one more after banks 3 and 7, giving 26 slots.
- R7: With speed_sel=3, wide_org=0, or with speed_sel=1, wide_org=1, one deselect follows every pair, plus two more after banks 3 and 7, giving 28 slots.
- R8: With speed_sel=2, wide_org=1, two deselects follow every pair, plus one more after banks 3 and 7, giving 34 slots.
- R9: In a deselect slot, cs_n is 1 and ras_n, cas_n, we_n, bank and addr keep the values of the previous command.
- R10: When a loop would begin with speed_sel=3 and wide_org=1, cfg_err goes to 1, every slot is a deselect, and loop_start stays 0. As soon as a valid selection is presented, cfg_err clears and a loop starts.
- R11: A change to speed_sel or wide_org during a loop has no effect until that loop's last slot has been issued.
- R12: loop_start is 1 for exactly the slot that carries the bank 0 activate, and 0 in every other slot.
- R13: Clearing enable makes the pins show deselects from the second clock edge onward. After enable is set again, the bank 0 activate appears on the pins at the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the command loop |
| speed_sel | input | 2 | Speed bin: 0=400, 1=533, 2=667, 3=800 |
| wide_org | input | 1 | 0 = x4/x8 device, 1 = x16 device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | 3 | Bank address |
| addr | output | 14 | Row/column address |
| cfg_err | output | 1 | Unsupported speed/width selection |
| loop_start | output | 1 | Marks the bank 0 activate slot |

## Verification
The pins lag the sequencer by one register. A change of enable or of a valid selection from a parked state therefore shows up at the second clock edge. The bench checks one cycle early that the pins are still idle, then expects the bank 0 activate exactly one cycle later. Within a loop, every slot is compared at the falling edge that follows the rising edge which produced it, against a slot list built from the gap counts in the requirements. Selects are changed in the first slot of a running loop. The rest of that loop is checked against the old shape, and the next loop against the new one, with no slot skipped between them. The error state is entered at the next boundary, so cfg_err is checked at the first idle slot after the old loop ends.

// File: rtl/ilv_seq_pkg.sv
package ilv_seq_pkg;

  typedef enum logic [1:0] {
    K_DES = 2'd0,
    K_ACT = 2'd1,
    K_RD  = 2'd2
  } slot_kind_e;

  typedef enum logic [1:0] {
    ST_PARK = 2'd0,
    ST_ACT  = 2'd1,
    ST_RD   = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;

  localparam int GAP_W = 2;

  // Shape of one loop: idle slots after every pair, extra idle slots
  // after each half of the bank set, and an unsupported-setting flag.
  typedef struct packed {
    logic [GAP_W-1:0] pair_gap;
    logic [GAP_W-1:0] half_gap;
    logic             bad;
  } loop_shape_t;

endpackage

// File: rtl/ilv_shape_decode.sv
module ilv_shape_decode
  import ilv_seq_pkg::*;
(
  input  logic [1:0]  speed_sel,
  input  logic        wide_org,
  output loop_shape_t shape
);

  always_comb begin
    shape = '0;
    if (!wide_org) begin
      unique case (speed_sel)
        2'd0: begin shape.pair_gap = 2'd0; shape.half_gap = 2'd0; end
        2'd1: begin shape.pair_gap = 2'd0; shape.half_gap = 2'd2; end
        2'd2: begin shape.pair_gap = 2'd1; shape.half_gap = 2'd1; end
        default: begin shape.pair_gap = 2'd1; shape.half_gap = 2'd2; end
      endcase
    end else begin
      unique case (speed_sel)
        2'd0: begin shape.pair_gap = 2'd0; shape.half_gap = 2'd2; end
        2'd1: begin shape.pair_gap = 2'd1; shape.half_gap = 2'd2; end
        2'd2: begin shape.pair_gap = 2'd2; shape.half_gap = 2'd1; end
        default: shape.bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ilv_slot_fsm.sv
module ilv_slot_fsm
  import ilv_seq_pkg::*;
#(
  parameter int N_BANKS = 8,
  localparam int BANK_W = $clog2(N_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  loop_shape_t       shape_in,
  output slot_kind_e        kind,
  output logic [BANK_W-1:0] bank_cur,
  output logic              err_q
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(N_BANKS - 1);
  localparam logic [BANK_W-1:0] HALF_BANK = BANK_W'(N_BANKS / 2 - 1);

  seq_state_e        st;
  logic [BANK_W-1:0] bank_q;
  logic [2:0]        gap_cnt;
  loop_shape_t       shape_q;

  logic       half_end;
  logic [2:0] gap_total;
  logic       step_pair;
  logic       boundary;

  always_comb begin
    half_end  = (bank_q == HALF_BANK) || (bank_q == LAST_BANK);
    gap_total = {1'b0, shape_q.pair_gap} + (half_end ? {1'b0, shape_q.half_gap} : 3'd0);
    step_pair = ((st == ST_RD) && (gap_total == 3'd0)) ||
                ((st == ST_GAP) && (gap_cnt == 3'd0));
    boundary  = (st == ST_PARK) || (step_pair && (bank_q == LAST_BANK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PARK;
      bank_q  <= '0;
      gap_cnt <= '0;
      shape_q <= '0;
      err_q   <= 1'b0;
    end else if (!enable) begin
      st    <= ST_PARK;
      err_q <= 1'b0;
    end else if (boundary) begin
      shape_q <= shape_in;
      bank_q  <= '0;
      err_q   <= shape_in.bad;
      st      <= shape_in.bad ? ST_PARK : ST_ACT;
    end else if (step_pair) begin
      st     <= ST_ACT;
      bank_q <= bank_q + BANK_W'(1);
    end else begin
      unique case (st)
        ST_ACT: st <= ST_RD;
        ST_RD: begin
          st      <= ST_GAP;
          gap_cnt <= gap_total - 3'd1;
        end
        ST_GAP: gap_cnt <= gap_cnt - 3'd1;
        default: st <= ST_PARK;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_ACT:  kind = K_ACT;
      ST_RD:   kind = K_RD;
      default: kind = K_DES;
    endcase
  end

  assign bank_cur = bank_q;

  // Observation state for the spacing and order checks below.
  logic [7:0]        since_act;
  logic              have_prev;
  logic [BANK_W-1:0] last_bank;
  logic [GAP_W-1:0]  last_pg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '0;
      have_prev <= 1'b0;
      last_bank <= '0;
      last_pg   <= '0;
    end else if (st == ST_PARK) begin
      have_prev <= 1'b0;
      since_act <= '0;
    end else if (st == ST_ACT) begin
      have_prev <= 1'b1;
      last_bank <= bank_q;
      last_pg   <= shape_q.pair_gap;
      since_act <= 8'd1;
    end else if (since_act != 8'hFF) begin
      since_act <= since_act + 8'd1;
    end
  end

  AST_RD_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |-> ($past(st) == ST_ACT && $stable(bank_q))); // R3

  AST_BANK_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && have_prev) |->
      (bank_q == ((last_bank == LAST_BANK) ? '0 : last_bank + BANK_W'(1)))); // R3

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && have_prev) |-> (since_act >= 8'd2 + 8'(last_pg))); // R3

  AST_ERR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st == ST_PARK)); // R10

  AST_NO_BAD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_PARK) |-> !shape_q.bad); // R10

endmodule

// File: rtl/ilv_cmd_drive.sv
module ilv_cmd_drive
  import ilv_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter logic [ADDR_W-1:0] ROW_ADDR = 'h0123,
  parameter logic [ADDR_W-1:0] COL_ADDR = 'h0008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_kind_e        kind,
  input  logic [BANK_W-1:0] bank_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              loop_start
);

  localparam logic [ADDR_W-1:0] RD_ADDR = COL_ADDR | (ADDR_W'(1) << AP_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n       <= 1'b1;
      ras_n      <= 1'b1;
      cas_n      <= 1'b1;
      we_n       <= 1'b1;
      bank       <= '0;
      addr       <= '0;
      loop_start <= 1'b0;
    end else begin
      loop_start <= (kind == K_ACT) && (bank_in == '0);
      unique case (kind)
        K_ACT: begin
          cs_n  <= 1'b0;
          ras_n <= 1'b0;
          cas_n <= 1'b1;
          we_n  <= 1'b1;
          bank  <= bank_in;
          addr  <= ROW_ADDR;
        end
        K_RD: begin
          cs_n  <= 1'b0;
          ras_n <= 1'b1;
          cas_n <= 1'b0;
          we_n  <= 1'b1;
          bank  <= bank_in;
          addr  <= RD_ADDR;
        end
        default: cs_n <= 1'b1;
      endcase
    end
  end

  AST_DES_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_DES) |=> (cs_n && $stable({ras_n, cas_n, we_n, bank, addr}))); // R9

  AST_RD_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ras_n && !cas_n && we_n) |-> addr[AP_BIT]); // R2

  AST_MARK_ON_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start |-> (!cs_n && !ras_n && cas_n && we_n && bank == '0)); // R12

  AST_ACT_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_ACT) |=> ##1 (!cs_n && ras_n && !cas_n && bank == $past(bank))); // R3

endmodule

// File: rtl/ilv_cmd_seq.sv
module ilv_cmd_seq
  import ilv_seq_pkg::*;
#(
  parameter int N_BANKS = 8,
  parameter int ADDR_W  = 14,
  parameter int AP_BIT  = 10,
  parameter logic [ADDR_W-1:0] ROW_ADDR = 'h0123,
  parameter logic [ADDR_W-1:0] COL_ADDR = 'h0008,
  localparam int BANK_W = $clog2(N_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        speed_sel,
  input  logic              wide_org,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              cfg_err,
  output logic              loop_start
);

  loop_shape_t       shape;
  slot_kind_e        kind;
  logic [BANK_W-1:0] bank_cur;

  ilv_shape_decode u_decode (
    .speed_sel (speed_sel),
    .wide_org  (wide_org),
    .shape     (shape)
  );

  ilv_slot_fsm #(
    .N_BANKS (N_BANKS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .shape_in (shape),
    .kind     (kind),
    .bank_cur (bank_cur),
    .err_q    (cfg_err)
  );

  ilv_cmd_drive #(
    .BANK_W   (BANK_W),
    .ADDR_W   (ADDR_W),
    .AP_BIT   (AP_BIT),
    .ROW_ADDR (ROW_ADDR),
    .COL_ADDR (COL_ADDR)
  ) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .bank_in    (bank_cur),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .bank       (bank),
    .addr       (addr),
    .loop_start (loop_start)
  );

endmodule

// File: tb/ilv_cmd_seq_tb.sv
module ilv_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  speed_sel = 2'd0;
  logic        wide_org = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [2:0]  bank;
  logic [13:0] addr;
  logic        cfg_err, loop_start;

  localparam logic [13:0] EXP_ROW = 14'h0123;
  localparam logic [13:0] EXP_RD  = 14'h0408;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [2:0]  last_rcw = 3'b111;
  logic [2:0]  last_b   = 3'd0;
  logic [13:0] last_a   = 14'd0;
  int cur_sp = 0;
  bit cur_wd = 1'b0;

  always #2 clk = ~clk;

  ilv_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
    .wide_org(wide_org), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank(bank), .addr(addr), .cfg_err(cfg_err),
    .loop_start(loop_start)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string cfg_tag(input int sp, input bit wd);
    if (!wd) return (sp == 0) ? "R4" : (sp == 1) ? "R5" : (sp == 2) ? "R6" : "R7";
    return (sp == 0) ? "R5" : (sp == 1) ? "R7" : "R8";
  endfunction

  function automatic int pair_gap(input int sp, input bit wd);
    if (!wd) return (sp < 2) ? 0 : 1;
    return sp;
  endfunction

  function automatic int half_gap(input int sp, input bit wd);
    if (!wd) return (sp == 0) ? 0 : (sp == 2) ? 1 : 2;
    return (sp == 2) ? 1 : 2;
  endfunction

  // kind: 0 deselect, 1 activate, 2 read with auto precharge
  task automatic check_slot(input int kind, input int b, input string req);
    logic [3:0]  ep;
    logic [2:0]  eb;
    logic [13:0] ea;
    logic        el;
    if (kind == 1) begin ep = 4'b0011; eb = 3'(b); ea = EXP_ROW; end
    else if (kind == 2) begin ep = 4'b0101; eb = 3'(b); ea = EXP_RD; end
    else begin ep = {1'b1, last_rcw}; eb = last_b; ea = last_a; end
    el = (kind == 1) && (b == 0);
    chk({cs_n, ras_n, cas_n, we_n} == ep, {req, " R2 R9"}, "cmd pins",
        {cs_n, ras_n, cas_n, we_n}, ep);
    chk(bank == eb, {req, " R3"}, "bank", bank, eb);
    chk(addr == ea, {req, " R2"}, "addr", addr, ea);
    chk(loop_start == el, {req, " R12"}, "loop_start", loop_start, el);
    if (kind != 0) begin last_rcw = ep[2:0]; last_b = eb; last_a = ea; end
    @(negedge clk);
  endtask

  // Entered at the falling edge that shows slot 0; leaves at the next slot 0.
  task automatic check_loop(input int sp, input bit wd, input string extra);
    string tag;
    tag = {cfg_tag(sp, wd), extra};
    for (int b = 0; b < 8; b++) begin
      check_slot(1, b, tag);
      check_slot(2, b, tag);
      for (int g = 0; g < pair_gap(sp, wd) + ((b == 3 || b == 7) ? half_gap(sp, wd) : 0); g++)
        check_slot(0, b, tag);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'hF, "R1", "cmd pins", {cs_n, ras_n, cas_n, we_n}, 4'hF);
    chk(bank == 3'd0 && addr == 14'd0, "R1", "bank/addr", {bank, addr}, 0);
    chk(!cfg_err && !loop_start, "R1", "err/marker", {cfg_err, loop_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_start(input int sp, input bit wd);
    speed_sel = 2'(sp);
    wide_org  = wd;
    enable    = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R13", "cs_n one edge after enable", cs_n, 1);
    @(negedge clk);
    cur_sp = sp;
    cur_wd = wd;
    check_loop(sp, wd, " R13");
  endtask

  task automatic t_switch(input int sp, input bit wd);
    speed_sel = 2'(sp);
    wide_org  = wd;
    check_loop(cur_sp, cur_wd, " R11");
    cur_sp = sp;
    cur_wd = wd;
    check_loop(cur_sp, cur_wd, " R11");
  endtask

  task automatic t_error;
    speed_sel = 2'd3;
    wide_org  = 1'b1;
    check_loop(cur_sp, cur_wd, " R11");
    for (int i = 0; i < 5; i++) begin
      chk(cfg_err == 1'b1, "R10", "cfg_err", cfg_err, 1);
      check_slot(0, 0, "R10");
    end
    speed_sel = 2'd2;
    wide_org  = 1'b1;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R10", "cfg_err clear", cfg_err, 0);
    chk(cs_n == 1'b1, "R10", "cs_n before restart", cs_n, 1);
    @(negedge clk);
    cur_sp = 2;
    cur_wd = 1'b1;
    check_loop(2, 1'b1, " R10");
  endtask

  task automatic t_disable;
    check_slot(1, 0, "R13");
    check_slot(2, 0, "R13");
    enable = 1'b0;
    check_slot(0, 0, "R13");
    for (int i = 0; i < 4; i++) check_slot(0, 0, "R13");
    enable = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R13", "cs_n one edge after re-enable", cs_n, 1);
    @(negedge clk);
    check_loop(cur_sp, cur_wd, " R13");
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_start(0, 1'b0);
    t_switch(1, 1'b0);
    t_switch(2, 1'b0);
    t_switch(3, 1'b0);
    t_switch(0, 1'b1);
    t_switch(1, 1'b1);
    t_switch(2, 1'b1);
    t_switch(0, 1'b0);
    t_error;
    t_disable;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
    end
  end

endmodule